// File: doc/BRIEF.md
# Vectored Interrupt Entry Sequencer

This block performs the hardware steps a processor takes when it accepts interrupt number i. When a request arrives and the interrupt-enable bit of the status word is set, the block latches the request number, the status word, the program counter and the stack pointer. It then runs its own memory transactions: it pushes the status word, pushes the program counter, and reads the handler address from the vector table. Finally it hands the processor a new program counter, a new stack pointer and a status word with interrupts disabled.

Each memory access is held on the port until the memory answers with a ready strobe. The stack grows downward in 4-byte words, with the status word stored first. The table entry for interrupt i sits at byte address 4·i. On the last step all three register updates are written at once and a one-cycle acknowledge is raised. The block does not choose between competing sources. It also does not handle the return from a handler.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, and until a request is accepted, `busy_o`, `mem_req_o`, `ack_o`, `pc_we_o`, `sp_we_o` and `psw_we_o` are low.
- R2: A request is accepted when `irq_req_i` is high and bit 0 of `psw_i` (interrupt enable) is 1. In the cycle after acceptance `busy_o` is high and the first access is a write of the latched status word to address sp−4, where sp is the latched stack pointer.
- R3: The second access is a write of the latched program counter to address sp−8.
- R4: The third access is a read at byte address 4·i, with address bits 1:0 equal to 0. It starts only after both writes have completed.
- R5: The word read in R4 is presented on `pc_o` with `pc_we_o` high, and `ack_o` is high for exactly one cycle in that same cycle. `busy_o` falls in the following cycle.
- R6: In the acknowledge cycle `sp_we_o` is high and `sp_o` equals sp−8.
- R7: In the acknowledge cycle `psw_we_o` is high and `psw_o` equals the latched status word with bit 0 cleared.
- R8: While `mem_rdy_i` is low, an access keeps `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` unchanged. The sequence advances only on a cycle in which `mem_rdy_i` is high.
- R9: Requests, and changes on `irq_num_i`, `psw_i`, `pc_i` and `sp_i`, have no effect while a sequence is in progress.
- R10: A request with bit 0 of `psw_i` clear is ignored. No memory access occurs and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 1 | Interrupt request |
| irq_num_i | input | IRQ_W | Interrupt number i |
| psw_i | input | DW | Current status word, bit 0 = interrupt enable |
| pc_i | input | AW | Current program counter |
| sp_i | input | AW | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | DW | Write data |
| mem_rdy_i | input | 1 | Access complete |
| mem_rdata_i | input | DW | Read data |
| pc_o | output | AW | New program counter (handler address) |
| pc_we_o | output | 1 | Load strobe for pc_o |
| sp_o | output | AW | New stack pointer |
| sp_we_o | output | 1 | Load strobe for sp_o |
| psw_o | output | DW | New status word, interrupts disabled |
| psw_we_o | output | 1 | Load strobe for psw_o |
| ack_o | output | 1 | One-cycle acknowledge on handler entry |
| busy_o | output | 1 | Sequence in progress |

## Verification
The embedded assertions check four things on every cycle. First, a pending access holds steady while ready is low. Second, the first access after `busy_o` rises is a write just below the sampled stack pointer. Third, vector reads are word aligned. Fourth, the acknowledge lasts one cycle and always comes with a status word whose enable bit is clear. Only the bench scenarios can show the data itself: the exact push order and values, the table address 4·i for every one of the 32 interrupt numbers, and the loaded handler address. They also show that the sequence is immune to requests and input changes mid-sequence, and that a request with interrupts disabled leaves the memory port idle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PSW,
    ST_PUSH_PC,
    ST_FETCH,
    ST_LOAD
  } entry_st_e;

  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
  parameter int unsigned IRQ_W = 5,
  parameter int unsigned AW    = 32
) (
  input  logic [IRQ_W-1:0] num_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned PAD_W = AW - IRQ_W - 2;

  // table entry i at byte address 4*i
  assign addr_o = {{PAD_W{1'b0}}, num_i, 2'b00};
endmodule

// File: rtl/irq_stack_calc.sv
module irq_stack_calc #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] sp_i,
  output logic [AW-1:0] slot_psw_o,
  output logic [AW-1:0] slot_pc_o
);
  import irq_entry_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  // downward-growing stack, status word pushed first
  assign slot_psw_o = sp_i - STEP;
  assign slot_pc_o  = sp_i - (STEP << 1);
endmodule

// File: rtl/irq_psw_mask.sv
module irq_psw_mask #(
  parameter int unsigned DW     = 32,
  parameter int unsigned IE_BIT = 0
) (
  input  logic [DW-1:0] psw_i,
  output logic          ie_o,
  output logic [DW-1:0] psw_masked_o
);
  localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;

  assign ie_o         = psw_i[IE_BIT];
  assign psw_masked_o = psw_i & ~IE_MASK;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned IRQ_W  = 5,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 32,
  parameter int unsigned IE_BIT = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_req_i,
  input  logic [IRQ_W-1:0] irq_num_i,
  input  logic [DW-1:0]    psw_i,
  input  logic [AW-1:0]    pc_i,
  input  logic [AW-1:0]    sp_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_rdy_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic [AW-1:0]    pc_o,
  output logic             pc_we_o,
  output logic [AW-1:0]    sp_o,
  output logic             sp_we_o,
  output logic [DW-1:0]    psw_o,
  output logic             psw_we_o,
  output logic             ack_o,
  output logic             busy_o
);
  import irq_entry_pkg::*;

  entry_st_e        state_q, state_d;
  logic [IRQ_W-1:0] num_q;
  logic [DW-1:0]    psw_q;
  logic [AW-1:0]    pc_q, sp_q, vec_q;

  logic             ie_in, ie_unused;
  logic [DW-1:0]    psw_in_masked, psw_save_masked;
  logic [AW-1:0]    vec_addr, slot_psw, slot_pc;
  logic             accept, st_load;

  irq_psw_mask #(.DW(DW), .IE_BIT(IE_BIT)) u_mask_in (
    .psw_i        (psw_i),
    .ie_o         (ie_in),
    .psw_masked_o (psw_in_masked)
  );

  irq_psw_mask #(.DW(DW), .IE_BIT(IE_BIT)) u_mask_save (
    .psw_i        (psw_q),
    .ie_o         (ie_unused),
    .psw_masked_o (psw_save_masked)
  );

  irq_vec_addr #(.IRQ_W(IRQ_W), .AW(AW)) u_vec (
    .num_i  (num_q),
    .addr_o (vec_addr)
  );

  irq_stack_calc #(.AW(AW)) u_stack (
    .sp_i       (sp_q),
    .slot_psw_o (slot_psw),
    .slot_pc_o  (slot_pc)
  );

  assign accept  = (state_q == ST_IDLE) && irq_req_i && ie_in;
  assign st_load = (state_q == ST_LOAD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (accept)    state_d = ST_PUSH_PSW;
      ST_PUSH_PSW: if (mem_rdy_i) state_d = ST_PUSH_PC;
      ST_PUSH_PC:  if (mem_rdy_i) state_d = ST_FETCH;
      ST_FETCH:    if (mem_rdy_i) state_d = ST_LOAD;
      ST_LOAD:                    state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      num_q   <= '0;
      psw_q   <= '0;
      pc_q    <= '0;
      sp_q    <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        num_q <= irq_num_i;
        psw_q <= psw_i;
        pc_q  <= pc_i;
        sp_q  <= sp_i;
      end
      if (state_q == ST_FETCH && mem_rdy_i) vec_q <= mem_rdata_i[AW-1:0];
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_PUSH_PSW: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_psw;
        mem_wdata_o = psw_q;
      end
      ST_PUSH_PC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = slot_pc;
        mem_wdata_o = DW'(pc_q);
      end
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = vec_addr;
      end
      default: ;
    endcase
  end

  assign pc_o     = st_load ? vec_q : '0;
  assign sp_o     = st_load ? slot_pc : '0;
  assign psw_o    = st_load ? psw_save_masked : '0;
  assign pc_we_o  = st_load;
  assign sp_we_o  = st_load;
  assign psw_we_o = st_load;
  assign ack_o    = st_load;
  assign busy_o   = (state_q != ST_IDLE);

  // R8
  hold_until_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rdy_i |=> mem_req_o && $stable(mem_addr_o)
                                && $stable(mem_we_o) && $stable(mem_wdata_o));

  // R2
  first_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> mem_req_o && mem_we_o
                      && mem_addr_o == $past(sp_i) - AW'(WORD_BYTES));

  // R4
  vec_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> mem_addr_o[1:0] == 2'b00);

  // R5
  ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o && !busy_o);

  // R7
  ie_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> psw_we_o && !psw_o[IE_BIT]);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [4:0]  irq_num = '0;
  logic [31:0] psw = '0, pc = '0, sp = '0;
  logic        mem_req, mem_we, mem_rdy;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] pc_o, sp_o, psw_o;
  logic        pc_we, sp_we, psw_we, ack, busy;

  int errors = 0, checks = 0;
  int wait_cfg = 0, wcnt = 0;
  int txn_cnt = 0, ack_cnt = 0;
  logic [31:0] log_addr[8], log_data[8];
  logic        log_we[8];
  logic [31:0] ack_pc, ack_sp, ack_psw;
  logic        ack_wes;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq_req), .irq_num_i(irq_num),
    .psw_i(psw), .pc_i(pc), .sp_i(sp),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdy_i(mem_rdy), .mem_rdata_i(mem_rdata),
    .pc_o(pc_o), .pc_we_o(pc_we), .sp_o(sp_o), .sp_we_o(sp_we),
    .psw_o(psw_o), .psw_we_o(psw_we), .ack_o(ack), .busy_o(busy)
  );

  // vector table: entry at address a holds 0x8000 + 4*a
  assign mem_rdata = 32'h8000 + (mem_addr << 2);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rdy <= 1'b0; wcnt <= 0;
    end else if (mem_rdy) begin
      mem_rdy <= 1'b0; wcnt <= 0;
    end else if (mem_req) begin
      if (wcnt >= wait_cfg) mem_rdy <= 1'b1;
      else wcnt <= wcnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_rdy) begin
        if (txn_cnt < 8) begin
          log_addr[txn_cnt] = mem_addr;
          log_data[txn_cnt] = mem_we ? mem_wdata : mem_rdata;
          log_we[txn_cnt]   = mem_we;
        end
        txn_cnt++;
      end
      if (ack) begin
        ack_cnt++;
        ack_pc = pc_o; ack_sp = sp_o; ack_psw = psw_o;
        ack_wes = pc_we && sp_we && psw_we;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_irq(input int n, input logic [31:0] p_sw,
                         input logic [31:0] p_c, input logic [31:0] s_p,
                         input bit disturb);
    int t0, a0;
    t0 = txn_cnt; a0 = ack_cnt;
    @(negedge clk);
    irq_req = 1'b1; irq_num = 5'(n); psw = p_sw; pc = p_c; sp = s_p;
    @(negedge clk);
    chk(busy === 1'b1, "R2 busy after accept", {31'b0, busy}, 32'h1);
    if (disturb) begin
      irq_num = 5'(n ^ 5'h13); pc = ~p_c; sp = s_p ^ 32'h0F00; psw = ~p_sw | 32'h1;
      repeat (3) @(negedge clk);
    end
    irq_req = 1'b0;
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(txn_cnt - t0 == 3, "R4 three accesses", 32'(txn_cnt - t0), 32'h3);
    chk(log_we[0] && log_addr[0] == s_p - 4 && log_data[0] == p_sw,
        "R2 psw push", log_addr[0], s_p - 4);
    chk(log_we[1] && log_addr[1] == s_p - 8 && log_data[1] == p_c,
        "R3 pc push", log_addr[1], s_p - 8);
    chk(!log_we[2] && log_addr[2] == 32'(4 * n), "R4 vector read",
        log_addr[2], 32'(4 * n));
    chk(ack_cnt - a0 == 1 && ack_wes && ack_pc == 32'h8000 + 32'(16 * n),
        "R5 handler pc", ack_pc, 32'h8000 + 32'(16 * n));
    chk(ack_sp == s_p - 8, "R6 new sp", ack_sp, s_p - 8);
    chk(ack_psw == (p_sw & ~32'h1), "R7 psw ie clear", ack_psw, p_sw & ~32'h1);
    txn_cnt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !mem_req && !ack && !pc_we && !sp_we && !psw_we, "R1 in reset",
        {26'b0, busy, mem_req, ack, pc_we, sp_we, psw_we}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req && !ack && !pc_we && !sp_we && !psw_we, "R1 after reset",
        {26'b0, busy, mem_req, ack, pc_we, sp_we, psw_we}, 32'h0);

    // R2..R8: every interrupt number, wait states 0..3
    for (int n = 0; n < 32; n++) begin
      wait_cfg = n % 4;
      run_irq(n, 32'h0000_0F01 ^ (32'(n) << 8), 32'h2000_0000 + 32'(n * 64),
              32'h0001_0000 - 32'(n * 256), 1'b0);
    end

    // R9: disturbance mid-sequence
    wait_cfg = 2;
    run_irq(7, 32'hA5A5_0003, 32'h3000_1234, 32'h0000_8000, 1'b1);
    repeat (4) @(negedge clk);
    chk(!busy && txn_cnt == 0, "R9 no restart", 32'(txn_cnt), 32'h0);

    // R10: interrupts disabled
    begin
      int a0;
      a0 = ack_cnt;
      @(negedge clk);
      irq_req = 1'b1; irq_num = 5'd9; psw = 32'hFFFF_FFFE;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        chk(!busy && !mem_req, "R10 ignored when disabled",
            {30'b0, busy, mem_req}, 32'h0);
      end
      irq_req = 1'b0;
      chk(txn_cnt == 0 && ack_cnt == a0, "R10 no access", 32'(txn_cnt), 32'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule